// File: doc/BRIEF.md
# Bandwidth-Limited In-Order Retire Controller

This block decides, once per cycle, how many instructions leave the head of a reorder buffer. The buffer shows a window of `WIDTH` consecutive head entries for the thread named on the select input. Each entry carries a ready bit, status flags, a sequence number and a PC. The controller walks the window from the oldest entry. It retires executed entries and drops squashed ones. It stops at the first entry that cannot leave this cycle, and for that entry it may raise a non-speculative execution request, an uncached-load request, a trap request or an error pulse. The retire mask it produces also serves as the write enable for the architectural rename map.

Each thread has a three-state machine. In `TS_RUN` the thread retires normally. The thread enters `TS_NSWAIT` after a non-speculative request. In that state a repeated request is suppressed, and the thread returns to `TS_RUN` on any retire or drop. The thread enters `TS_TRAP` when a fault is taken. In that state it retires nothing and returns to `TS_RUN` when its `trap_clear` bit is set. From `TS_NSWAIT`, a fault that is taken also moves the thread to `TS_TRAP`. For each thread, registered outputs give the last retired sequence number and the next PC. Three event counters record non-no-op retires, squashed removals and cycles in which the full width was retired.

Top module: `retire_ctl`

## Requirements
- R1: Starting at slot 0, each ready, executed, non-faulting slot retires (its `retire_we` bit is 1) until a slot is not ready or a stop condition occurs; no slot past the first stop retires.
- R2: A ready squashed slot sets its `drop_we` bit, does not count as a retire for the first-slot rule, and adds one to `cnt_squash` at the next edge.
- R3: An unexecuted slot flagged non-speculative or barrier stops the walk. It raises `nonspec_req` with `clr_cancommit`, its slot index on `clr_slot` and its sequence number on `req_seq` only when nothing has retired earlier in the cycle, `stores_pending` is 0 and the thread is not in `TS_NSWAIT`. A request moves the thread to `TS_NSWAIT`.
- R4: In `TS_NSWAIT` no new non-speculative request is raised; any retire or drop for that thread returns it to `TS_RUN`.
- R5: An unexecuted slot flagged load (and not non-speculative or barrier) stops the walk and raises `uncached_req` with `clr_cancommit`, the slot index and its sequence number, whatever its position.
- R6: An unexecuted slot with none of non-speculative, barrier or load set stops the walk and pulses `unexec_err`; at most one of the four request outputs is high in a cycle.
- R7: An executed faulting slot never retires and stops the walk. It raises `trap_req` and moves the thread to `TS_TRAP` only when it is the first retire candidate of the cycle and `stores_pending` is 0.
- R8: A thread in `TS_TRAP` retires and drops nothing and raises no request until `trap_clear` for it is 1, which returns it to `TS_RUN` at the next edge.
- R9: After a cycle with at least one retire, `done_seq` of the thread equals the sequence number of the youngest retired slot and `next_pc` equals that slot's PC plus 4.
- R10: `cnt_commit` adds the number of retired slots whose no-op flag is 0.
- R11: `cnt_bwlim` adds one after each cycle in which all `WIDTH` slots retired.
- R12: After reset every thread is in `TS_RUN` and all registered outputs are zero.
- R13: With `sel_valid` at 0 nothing retires, drops or is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_valid | input | 1 | A thread is selected this cycle |
| sel_tid | input | TIDW | Selected thread |
| stores_pending | input | 1 | Stores await writeback |
| hd_ready | input | WIDTH | Slot holds a candidate that may be examined |
| hd_squashed | input | WIDTH | Slot was squashed |
| hd_executed | input | WIDTH | Slot finished execution |
| hd_nonspec | input | WIDTH | Slot must execute non-speculatively |
| hd_barrier | input | WIDTH | Slot is a barrier or store-conditional |
| hd_load | input | WIDTH | Slot is a load |
| hd_fault | input | WIDTH | Slot carries a fault |
| hd_nop | input | WIDTH | Slot is a no-op or instruction prefetch |
| hd_seq | input | WIDTH*SEQW | Per-slot sequence numbers, slot 0 lowest |
| hd_pc | input | WIDTH*PCW | Per-slot PCs, slot 0 lowest |
| trap_clear | input | NT | Per-thread release from trap wait |
| retire_we | output | WIDTH | Retire pulse per slot; rename-map write enable |
| drop_we | output | WIDTH | Squashed-slot removal per slot |
| nonspec_req | output | 1 | Non-speculative execution request |
| uncached_req | output | 1 | Uncached load request |
| trap_req | output | 1 | Trap request |
| unexec_err | output | 1 | Unexecuted slot of unsupported type |
| clr_cancommit | output | 1 | Clear the can-commit flag of `clr_slot` |
| clr_slot | output | SLOTW | Slot addressed by the request |
| req_seq | output | SEQW | Sequence number for the request |
| done_seq | output | NT*SEQW | Last retired sequence number per thread |
| next_pc | output | NT*PCW | Next PC per thread |
| cnt_commit | output | CNTW | Counted retires |
| cnt_squash | output | CNTW | Squashed removals |
| cnt_bwlim | output | CNTW | Full-width cycles |

## Verification
The assertions assume that the ready bits of the window present as a prefix of candidates, and that `sel_tid` stays below `NT`. They also assume that `trap_clear` is raised only for a thread waiting on a trap, while that thread is not being examined. The bench selects thread 0 or 1 only, and raises a trap release in a cycle where no thread is selected. Every window it drives is a deliberate scenario, so the properties see only input combinations inside these limits.

// File: rtl/retire_pkg.sv
package retire_pkg;
    typedef enum logic [1:0] {
        TS_RUN    = 2'd0,
        TS_NSWAIT = 2'd1,
        TS_TRAP   = 2'd2
    } thr_state_e;
endpackage

// File: rtl/retire_scan.sv
module retire_scan #(
    parameter int WIDTH = 4,
    parameter int SEQW  = 16,
    parameter int PCW   = 32,
    parameter int CW    = 3,
    parameter int SLOTW = 2
) (
    input  logic               en,
    input  logic               waiting,
    input  logic               stores_pending,
    input  logic [WIDTH-1:0]   hd_ready,
    input  logic [WIDTH-1:0]   hd_squashed,
    input  logic [WIDTH-1:0]   hd_executed,
    input  logic [WIDTH-1:0]   hd_nonspec,
    input  logic [WIDTH-1:0]   hd_barrier,
    input  logic [WIDTH-1:0]   hd_load,
    input  logic [WIDTH-1:0]   hd_fault,
    input  logic [WIDTH-1:0]   hd_nop,
    input  logic [WIDTH*SEQW-1:0] hd_seq,
    input  logic [WIDTH*PCW-1:0]  hd_pc,
    output logic [WIDTH-1:0]   retire_we,
    output logic [WIDTH-1:0]   drop_we,
    output logic               ns_req,
    output logic               unc_req,
    output logic               trap_req,
    output logic               err,
    output logic               clr,
    output logic [SLOTW-1:0]   clr_slot,
    output logic [SEQW-1:0]    req_seq,
    output logic               last_valid,
    output logic [SEQW-1:0]    last_seq,
    output logic [PCW-1:0]     last_pc,
    output logic [CW-1:0]      n_ret,
    output logic [CW-1:0]      n_cnt,
    output logic [CW-1:0]      n_drop
);
    logic go;

    always_comb begin
        retire_we  = '0;
        drop_we    = '0;
        ns_req     = 1'b0;
        unc_req    = 1'b0;
        trap_req   = 1'b0;
        err        = 1'b0;
        clr        = 1'b0;
        clr_slot   = '0;
        req_seq    = '0;
        last_valid = 1'b0;
        last_seq   = '0;
        last_pc    = '0;
        n_ret      = '0;
        n_cnt      = '0;
        n_drop     = '0;
        go         = en;
        for (int i = 0; i < WIDTH; i++) begin
            if (go) begin
                if (!hd_ready[i]) begin
                    go = 1'b0;
                end else if (hd_squashed[i]) begin
                    drop_we[i] = 1'b1;
                    n_drop     = n_drop + 1'b1;
                end else if (!hd_executed[i]) begin
                    go = 1'b0;
                    if (hd_nonspec[i] || hd_barrier[i]) begin
                        if (n_ret == '0 && !stores_pending && !waiting) begin
                            ns_req   = 1'b1;
                            clr      = 1'b1;
                            clr_slot = SLOTW'(i);
                            req_seq  = hd_seq[i*SEQW +: SEQW];
                        end
                    end else if (hd_load[i]) begin
                        unc_req  = 1'b1;
                        clr      = 1'b1;
                        clr_slot = SLOTW'(i);
                        req_seq  = hd_seq[i*SEQW +: SEQW];
                    end else begin
                        err = 1'b1;
                    end
                end else if (hd_fault[i]) begin
                    go = 1'b0;
                    if (n_ret == '0 && !stores_pending) trap_req = 1'b1;
                end else begin
                    retire_we[i] = 1'b1;
                    n_ret        = n_ret + 1'b1;
                    if (!hd_nop[i]) n_cnt = n_cnt + 1'b1;
                    last_valid   = 1'b1;
                    last_seq     = hd_seq[i*SEQW +: SEQW];
                    last_pc      = hd_pc[i*PCW +: PCW];
                end
            end
        end
    end
endmodule

// File: rtl/retire_thr.sv
module retire_thr
    import retire_pkg::*;
#(
    parameter int NT         = 2,
    parameter int TIDW       = 1,
    parameter int SEQW       = 16,
    parameter int PCW        = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_valid,
    input  logic [TIDW-1:0]   sel_tid,
    input  logic              ns_ev,
    input  logic              trap_ev,
    input  logic              leave_ev,
    input  logic              last_valid,
    input  logic [SEQW-1:0]   last_seq,
    input  logic [PCW-1:0]    last_pc,
    input  logic [NT-1:0]     trap_clear,
    output logic [NT*2-1:0]   state_o,
    output logic [NT*SEQW-1:0] done_o,
    output logic [NT*PCW-1:0]  pc_o
);
    for (genvar t = 0; t < NT; t++) begin : g_thr
        thr_state_e st_q, st_d;
        logic       hit;

        assign hit = sel_valid && (sel_tid == TIDW'(t));

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                TS_RUN: begin
                    if (hit && trap_ev)    st_d = TS_TRAP;
                    else if (hit && ns_ev) st_d = TS_NSWAIT;
                end
                TS_NSWAIT: begin
                    if (hit && trap_ev)       st_d = TS_TRAP;
                    else if (hit && leave_ev) st_d = TS_RUN;
                end
                TS_TRAP: begin
                    if (trap_clear[t]) st_d = TS_RUN;
                end
                default: st_d = TS_RUN;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= TS_RUN;
            else        st_q <= st_d;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                done_o[t*SEQW +: SEQW] <= '0;
                pc_o[t*PCW +: PCW]     <= '0;
            end else if (hit && last_valid) begin
                done_o[t*SEQW +: SEQW] <= last_seq;
                pc_o[t*PCW +: PCW]     <= last_pc + PCW'(INSN_BYTES);
            end
        end

        assign state_o[t*2 +: 2] = st_q;
    end
endmodule

// File: rtl/retire_ctl.sv
module retire_ctl
    import retire_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter int NT         = 2,
    parameter int SEQW       = 16,
    parameter int PCW        = 32,
    parameter int CNTW       = 16,
    parameter int INSN_BYTES = 4,
    localparam int TIDW      = (NT > 1) ? $clog2(NT) : 1,
    localparam int SLOTW     = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_valid,
    input  logic [TIDW-1:0]       sel_tid,
    input  logic                  stores_pending,
    input  logic [WIDTH-1:0]      hd_ready,
    input  logic [WIDTH-1:0]      hd_squashed,
    input  logic [WIDTH-1:0]      hd_executed,
    input  logic [WIDTH-1:0]      hd_nonspec,
    input  logic [WIDTH-1:0]      hd_barrier,
    input  logic [WIDTH-1:0]      hd_load,
    input  logic [WIDTH-1:0]      hd_fault,
    input  logic [WIDTH-1:0]      hd_nop,
    input  logic [WIDTH*SEQW-1:0] hd_seq,
    input  logic [WIDTH*PCW-1:0]  hd_pc,
    input  logic [NT-1:0]         trap_clear,
    output logic [WIDTH-1:0]      retire_we,
    output logic [WIDTH-1:0]      drop_we,
    output logic                  nonspec_req,
    output logic                  uncached_req,
    output logic                  trap_req,
    output logic                  unexec_err,
    output logic                  clr_cancommit,
    output logic [SLOTW-1:0]      clr_slot,
    output logic [SEQW-1:0]       req_seq,
    output logic [NT*SEQW-1:0]    done_seq,
    output logic [NT*PCW-1:0]     next_pc,
    output logic [CNTW-1:0]       cnt_commit,
    output logic [CNTW-1:0]       cnt_squash,
    output logic [CNTW-1:0]       cnt_bwlim
);
    localparam int CW = $clog2(WIDTH + 1);

    logic [NT*2-1:0] thr_state;
    thr_state_e      sel_st;
    logic            last_valid;
    logic [SEQW-1:0] last_seq;
    logic [PCW-1:0]  last_pc;
    logic [CW-1:0]   n_ret, n_cnt, n_drop;

    assign sel_st = thr_state_e'(thr_state[int'(sel_tid)*2 +: 2]);

    retire_scan #(
        .WIDTH(WIDTH), .SEQW(SEQW), .PCW(PCW), .CW(CW), .SLOTW(SLOTW)
    ) scan_i (
        .en             (sel_valid && (sel_st != TS_TRAP)),
        .waiting        (sel_st == TS_NSWAIT),
        .stores_pending (stores_pending),
        .hd_ready       (hd_ready),
        .hd_squashed    (hd_squashed),
        .hd_executed    (hd_executed),
        .hd_nonspec     (hd_nonspec),
        .hd_barrier     (hd_barrier),
        .hd_load        (hd_load),
        .hd_fault       (hd_fault),
        .hd_nop         (hd_nop),
        .hd_seq         (hd_seq),
        .hd_pc          (hd_pc),
        .retire_we      (retire_we),
        .drop_we        (drop_we),
        .ns_req         (nonspec_req),
        .unc_req        (uncached_req),
        .trap_req       (trap_req),
        .err            (unexec_err),
        .clr            (clr_cancommit),
        .clr_slot       (clr_slot),
        .req_seq        (req_seq),
        .last_valid     (last_valid),
        .last_seq       (last_seq),
        .last_pc        (last_pc),
        .n_ret          (n_ret),
        .n_cnt          (n_cnt),
        .n_drop         (n_drop)
    );

    retire_thr #(
        .NT(NT), .TIDW(TIDW), .SEQW(SEQW), .PCW(PCW), .INSN_BYTES(INSN_BYTES)
    ) thr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_valid  (sel_valid),
        .sel_tid    (sel_tid),
        .ns_ev      (nonspec_req),
        .trap_ev    (trap_req),
        .leave_ev   ((|retire_we) || (|drop_we)),
        .last_valid (last_valid),
        .last_seq   (last_seq),
        .last_pc    (last_pc),
        .trap_clear (trap_clear),
        .state_o    (thr_state),
        .done_o     (done_seq),
        .pc_o       (next_pc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_commit <= '0;
            cnt_squash <= '0;
            cnt_bwlim  <= '0;
        end else begin
            cnt_commit <= cnt_commit + CNTW'(n_cnt);
            cnt_squash <= cnt_squash + CNTW'(n_drop);
            if (n_ret == CW'(WIDTH)) cnt_bwlim <= cnt_bwlim + 1'b1;
        end
    end
endmodule

// File: rtl/retire_ctl_chk.sv
module retire_ctl_chk #(
    parameter int WIDTH = 4,
    parameter int NT    = 2,
    parameter int TIDW  = 1,
    parameter int CNTW  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_valid,
    input logic [TIDW-1:0]  sel_tid,
    input logic             stores_pending,
    input logic [WIDTH-1:0] retire_we,
    input logic [WIDTH-1:0] drop_we,
    input logic             nonspec_req,
    input logic             uncached_req,
    input logic             trap_req,
    input logic             unexec_err,
    input logic [NT*2-1:0]  thr_state,
    input logic [CNTW-1:0]  cnt_bwlim
);
    logic [TIDW-1:0] tid_q;
    logic [1:0]      cur_st, prev_st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tid_q <= '0;
        else        tid_q <= sel_tid;
    end

    assign cur_st  = thr_state[int'(sel_tid)*2 +: 2];
    assign prev_st = thr_state[int'(tid_q)*2 +: 2];

    assert_disjoint_masks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_we & drop_we) == '0);

    assert_nonspec_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nonspec_req |-> (!stores_pending && retire_we == '0));

    assert_single_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nonspec_req, uncached_req, trap_req, unexec_err}));

    assert_trap_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (!stores_pending && retire_we == '0));

    assert_trap_enters_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (prev_st == 2'd2));

    assert_trapped_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && cur_st == 2'd2) |->
            (retire_we == '0 && drop_we == '0 && !nonspec_req && !trap_req));

    assert_bwlim_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (&retire_we) |=> (cnt_bwlim == $past(cnt_bwlim) + 1'b1));
endmodule

bind retire_ctl retire_ctl_chk #(
    .WIDTH(WIDTH), .NT(NT), .TIDW(TIDW), .CNTW(CNTW)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .sel_valid      (sel_valid),
    .sel_tid        (sel_tid),
    .stores_pending (stores_pending),
    .retire_we      (retire_we),
    .drop_we        (drop_we),
    .nonspec_req    (nonspec_req),
    .uncached_req   (uncached_req),
    .trap_req       (trap_req),
    .unexec_err     (unexec_err),
    .thr_state      (thr_state),
    .cnt_bwlim      (cnt_bwlim)
);

// File: tb/retire_ctl_tb.sv
`timescale 1ns/1ps
module retire_ctl_tb_top;
    localparam int W = 4, NT = 2, SEQW = 16, PCW = 32, CNTW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          sel_valid = 1'b0;
    logic [0:0]    sel_tid = '0;
    logic          stp = 1'b0;
    logic [W-1:0]  rdy = '0, sq = '0, ex = '0, ns = '0, bar = '0, ld = '0, flt = '0, nop = '0;
    logic [SEQW-1:0] sv [W];
    logic [PCW-1:0]  pv [W];
    logic [W*SEQW-1:0] seq_flat;
    logic [W*PCW-1:0]  pc_flat;
    logic [NT-1:0] tclr = '0;

    logic [W-1:0]  retire_we, drop_we;
    logic          nonspec_req, uncached_req, trap_req, unexec_err, clr_cancommit;
    logic [1:0]    clr_slot;
    logic [SEQW-1:0] req_seq;
    logic [NT*SEQW-1:0] done_seq;
    logic [NT*PCW-1:0]  next_pc;
    logic [CNTW-1:0] cnt_commit, cnt_squash, cnt_bwlim;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            seq_flat[i*SEQW +: SEQW] = sv[i];
            pc_flat[i*PCW +: PCW]    = pv[i];
        end
    end

    retire_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_tid(sel_tid),
        .stores_pending(stp), .hd_ready(rdy), .hd_squashed(sq), .hd_executed(ex),
        .hd_nonspec(ns), .hd_barrier(bar), .hd_load(ld), .hd_fault(flt), .hd_nop(nop),
        .hd_seq(seq_flat), .hd_pc(pc_flat), .trap_clear(tclr),
        .retire_we(retire_we), .drop_we(drop_we), .nonspec_req(nonspec_req),
        .uncached_req(uncached_req), .trap_req(trap_req), .unexec_err(unexec_err),
        .clr_cancommit(clr_cancommit), .clr_slot(clr_slot), .req_seq(req_seq),
        .done_seq(done_seq), .next_pc(next_pc), .cnt_commit(cnt_commit),
        .cnt_squash(cnt_squash), .cnt_bwlim(cnt_bwlim)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    // reference state: 0 running, 1 waiting on non-speculative, 2 trapped
    int mst [NT];
    int mdone [NT];
    longint mpc [NT];
    int mcc = 0, msq = 0, mbw = 0;
    // reference decision for the current cycle
    logic [W-1:0] e_ret, e_drop;
    bit e_ns, e_unc, e_trap, e_err, e_clr;
    int e_slot, e_rseq, e_lseq, nret, ncnt, ndrop;
    bit e_lv;
    longint e_lpc;

    task automatic chk(string req, string sc, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", req, sc, act, exp);
        end
    endtask

    // kinds: 0 not ready, 1 executed, 2 squashed, 3 unexec nonspec, 4 unexec barrier,
    // 5 unexec load, 6 unexec plain, 7 executed fault, 8 executed no-op
    task automatic put(int i, int kind, int seq);
        rdy[i] = (kind != 0); sq[i] = (kind == 2);
        ex[i]  = (kind == 1 || kind == 7 || kind == 8);
        ns[i]  = (kind == 3); bar[i] = (kind == 4); ld[i] = (kind == 5);
        flt[i] = (kind == 7); nop[i] = (kind == 8);
        sv[i]  = SEQW'(seq); pv[i] = PCW'(32'h1000 + 4*seq);
    endtask

    task automatic win(int k0, int k1, int k2, int k3, int base);
        put(0, k0, base); put(1, k1, base + 1); put(2, k2, base + 2); put(3, k3, base + 3);
    endtask

    task automatic model_comb();
        int st;
        bit go;
        st = mst[sel_tid];
        go = sel_valid && (st != 2);
        e_ret = '0; e_drop = '0; e_ns = 0; e_unc = 0; e_trap = 0; e_err = 0; e_clr = 0;
        e_slot = 0; e_rseq = 0; e_lv = 0; e_lseq = 0; e_lpc = 0; nret = 0; ncnt = 0; ndrop = 0;
        for (int i = 0; i < W; i++) begin
            if (!go) continue;
            if (!rdy[i]) go = 0;
            else if (sq[i]) begin e_drop[i] = 1; ndrop++; end
            else if (!ex[i]) begin
                go = 0;
                if (ns[i] || bar[i]) begin
                    if (nret == 0 && !stp && st != 1) begin
                        e_ns = 1; e_clr = 1; e_slot = i; e_rseq = sv[i];
                    end
                end else if (ld[i]) begin
                    e_unc = 1; e_clr = 1; e_slot = i; e_rseq = sv[i];
                end else e_err = 1;
            end else if (flt[i]) begin
                go = 0;
                if (nret == 0 && !stp) e_trap = 1;
            end else begin
                e_ret[i] = 1; nret++;
                if (!nop[i]) ncnt++;
                e_lv = 1; e_lseq = sv[i]; e_lpc = pv[i];
            end
        end
    endtask

    task automatic model_update();
        for (int t = 0; t < NT; t++)
            if (tclr[t] && mst[t] == 2) mst[t] = 0;
        if (sel_valid) begin
            if (e_trap) mst[sel_tid] = 2;
            else if (e_ns && mst[sel_tid] == 0) mst[sel_tid] = 1;
            else if (mst[sel_tid] == 1 && (nret + ndrop) > 0) mst[sel_tid] = 0;
            if (e_lv) begin
                mdone[sel_tid] = e_lseq;
                mpc[sel_tid]   = (e_lpc + 4) & 64'hFFFF_FFFF;
            end
        end
        mcc += ncnt; msq += ndrop;
        if (nret == W) mbw++;
    endtask

    task automatic check_regs(string sc);
        for (int t = 0; t < NT; t++) begin
            chk("R9", sc, done_seq[t*SEQW +: SEQW], mdone[t]);
            chk("R9", sc, next_pc[t*PCW +: PCW], mpc[t]);
        end
        chk("R10", sc, cnt_commit, mcc);
        chk("R2", sc, cnt_squash, msq);
        chk("R11", sc, cnt_bwlim, mbw);
    endtask

    // inputs are set at the falling edge; decisions sampled 1 ns later
    task automatic step(string sc);
        #1;
        model_comb();
        chk("R1", sc, retire_we, e_ret);
        chk("R2", sc, drop_we, e_drop);
        chk("R3", sc, nonspec_req, e_ns);
        chk("R5", sc, uncached_req, e_unc);
        chk("R6", sc, unexec_err, e_err);
        chk("R7", sc, trap_req, e_trap);
        chk("R3", sc, {clr_cancommit, clr_slot}, {e_clr, 2'(e_slot)});
        if (e_clr) chk("R3", sc, req_seq, e_rseq);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_regs(sc);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NT; t++) begin mst[t] = 0; mdone[t] = 0; mpc[t] = 0; end
        win(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_regs("R12_reset");
        chk("R12", "reset", {retire_we, drop_we, nonspec_req, trap_req}, 0);

        sel_valid = 1; sel_tid = 0;
        win(1, 1, 1, 1, 10);  step("R1_full_width");
        win(1, 1, 1, 0, 20);  step("R1_stop_not_ready");
        win(1, 8, 1, 8, 30);  step("R10_nops");
        win(2, 3, 1, 1, 40);  step("R2_squash_then_nonspec_first");
        win(3, 1, 1, 1, 41);  step("R4_no_rerequest");
        win(1, 1, 0, 0, 41);  step("R4_executed_retires");
        win(1, 3, 1, 1, 50);  step("R3_nonspec_not_first");
        stp = 1;
        win(4, 1, 1, 1, 51);  step("R3_barrier_stores_pending");
        win(7, 1, 1, 1, 51);  step("R7_fault_stores_pending");
        stp = 0;
        win(1, 1, 5, 1, 60);  step("R5_uncached_load_slot2");
        win(1, 6, 1, 1, 70);  step("R6_unexec_plain");
        win(1, 7, 1, 1, 80);  step("R7_fault_not_first");
        win(2, 2, 2, 2, 90);  step("R2_all_squashed");
        sel_tid = 1;
        win(7, 1, 1, 1, 200); step("R7_trap_thread1");
        win(1, 1, 1, 1, 201); step("R8_trapped_stall");
        sel_valid = 0; tclr = 2'b10;
        step("R13_no_select_with_release");
        tclr = 2'b00; sel_valid = 1;
        win(1, 1, 1, 1, 201); step("R8_after_release");
        sel_tid = 0;
        win(2, 1, 8, 3, 100); step("R9_mixed_thread0");
        sel_valid = 0;
        win(1, 1, 1, 1, 300); step("R13_idle");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule